// File: doc/BRIEF.md
# Adaptive DRAM Page-Close Policy Controller

This block advises a DRAM controller whether to close a row after an access or to leave it open. It learns from the outcome of earlier choices. The controller reports each resolved access. Leaving a row open and then taking a miss counts as a mistake in one direction. Closing a row and then losing a hit that would have landed there counts as a mistake in the other direction. A 4-bit saturating count records the balance between these two kinds of mistake. Two thresholds, with a band of hysteresis between them, turn that count into a choice between two algorithms. One is an aggressive-close algorithm, which closes the row at once. The other is a keep-open algorithm.

Under the keep-open algorithm, each row left open is guarded by a timeout. A new access to the same row restarts the timeout while it is still running. When the timeout expires, the block asks the controller to close the row. Under the aggressive-close algorithm, every access is followed by an immediate close request. A rate setting limits how often outcome reports may move the count. An enable input switches the learning off and pins the keep-open policy.

Top module: `pc_page_policy`

## Requirements
- R1: While reset is asserted, `policy_close` and `close_req` are 0. After reset, the mistake count starts at `cfg_init_cnt` and the keep-open algorithm is selected.
- R2: An accepted outcome report with `ev_was_open`=1 and `ev_hit`=0 raises the count by one. One with `ev_was_open`=0 and `ev_hit`=1 lowers it by one. The two other combinations leave the count unchanged.
- R3: The count saturates at 15 and at 0 and never wraps.
- R4: `policy_close`=1 means aggressive-close and 0 means keep-open. Keep-open changes to aggressive-close only on a raise whose result exceeds `cfg_hi_thr`. Aggressive-close changes to keep-open only on a lowering whose result is below `cfg_lo_thr`. Otherwise the selection holds, and the change is visible in the cycle after the report.
- R5: After a report is accepted in cycle t, reports in cycles t+1 to t+I-1 are dropped, where I is `cfg_interval`. A value of 0 behaves as 1.
- R6: While `cfg_enable` is 0, `policy_close` is 0 and reports are ignored. The count is held at `cfg_init_cnt`, so learning restarts from that value once the block is enabled again.
- R7: Under keep-open, an access that opens a new row (`acc_valid`=1, `acc_same_row`=0) starts the timer. If nothing follows, `close_req` is 1 for exactly one cycle, T cycles after the access, where T is `cfg_timeout`. A value of 0 behaves as 1.
- R8: Under keep-open, a same-row access while the timer is running restarts the full timeout. This holds even in the cycle in which the timer would otherwise have expired, and that expiry then produces no close request.
- R9: A same-row access while no timer is running, after an expiry or with no row open, starts nothing and causes no later `close_req`.
- R10: Under aggressive-close, every access produces `close_req`=1 in the next cycle and cancels any running timer, so no timeout-based close follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Adaptive policy enable |
| cfg_hi_thr | input | CNT_W | Count above which aggressive-close is entered |
| cfg_lo_thr | input | CNT_W | Count below which keep-open is entered |
| cfg_init_cnt | input | CNT_W | Starting mistake count |
| cfg_timeout | input | TMR_W | Open-row lifetime in cycles |
| cfg_interval | input | IVL_W | Minimum cycles between accepted reports |
| ev_valid | input | 1 | Outcome report present |
| ev_hit | input | 1 | Reported access was a page hit |
| ev_was_open | input | 1 | Row had been left open before that access |
| acc_valid | input | 1 | An access is issued this cycle |
| acc_same_row | input | 1 | The access targets the row currently held open |
| policy_close | output | 1 | 1 = aggressive-close, 0 = keep-open |
| close_req | output | 1 | Request to close the open row |

## Verification
The collision that matters is a same-row access that arrives in the very cycle the open-row timer would expire. The bench opens a row and then places the same-row access at every offset from one cycle up to the expiry cycle. It also tries the cycle just after expiry. The close pulse must then appear only one full timeout after the restart, or only at the first expiry when the late access is ignored. A second collision comes from the rate gate: reports arrive every cycle, so some are dropped while others are accepted. The cycle in which the policy flips must match the count of accepted reports alone.

// File: rtl/pc_pkg.sv
// Package pc_pkg
// Shared types for the adaptive page-close policy block: the kind of move an
// outcome report asks of the mistake count, and the two policy algorithms.
// Assumes the outcome report carries a hit flag and a was-left-open flag.
package pc_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_UP   = 2'd1,
        EV_DOWN = 2'd2
    } ev_e;

    typedef enum logic {
        ALG_KEEP  = 1'b0,
        ALG_CLOSE = 1'b1
    } alg_e;

    // Map an outcome report to a count move; correct guesses move nothing.
    function automatic ev_e classify(input logic hit, input logic was_open);
        if (was_open && !hit) begin
            return EV_UP;
        end
        if (!was_open && hit) begin
            return EV_DOWN;
        end
        return EV_NONE;
    endfunction

endpackage

// File: rtl/pc_rate_gate.sv
// Module pc_rate_gate
// Lets at most one outcome report through per configured interval. After a
// report is taken, a countdown blocks further reports for interval-1 cycles;
// reports arriving meanwhile are dropped. Interval 0 is treated as 1.
// Assumes the interval setting is static while traffic flows.
module pc_rate_gate #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             req,
    input  logic [IVL_W-1:0] ivl,
    output logic             take
);

    logic [IVL_W-1:0] wait_q;

    // A report is taken when enabled and no blocking window is active.
    always_comb begin
        take = en && req && (wait_q == '0);
    end

    // Load the blocking window on a take, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (take) begin
            wait_q <= (ivl == '0) ? '0 : ivl - 1'b1;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

endmodule

// File: rtl/pc_mistake_track.sv
// Module pc_mistake_track
// Saturating mistake count plus the hysteresis selector. Raises switch to
// the aggressive-close algorithm once the result exceeds the high threshold;
// lowerings switch back once the result drops below the low threshold.
// While disabled the count is reloaded from the initial value and the
// keep-open algorithm is forced. Assumes thresholds are static during use.
module pc_mistake_track
    import pc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             take,
    input  ev_e              ev,
    input  logic [CNT_W-1:0] hi_thr,
    input  logic [CNT_W-1:0] lo_thr,
    input  logic [CNT_W-1:0] init_cnt,
    output logic [CNT_W-1:0] cnt,
    output alg_e             alg
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    alg_e             alg_q, alg_d;

    // Next count and selection for an accepted report.
    always_comb begin
        cnt_d = cnt_q;
        alg_d = alg_q;
        if (take) begin
            case (ev)
                EV_UP: begin
                    if (cnt_q != CNT_MAX) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                    if (cnt_d > hi_thr) begin
                        alg_d = ALG_CLOSE;
                    end
                end
                EV_DOWN: begin
                    if (cnt_q != CNT_MIN) begin
                        cnt_d = cnt_q - 1'b1;
                    end
                    if (cnt_d < lo_thr) begin
                        alg_d = ALG_KEEP;
                    end
                end
                default: begin
                    cnt_d = cnt_q;
                end
            endcase
        end
    end

    // Register the count and selection; disable restarts learning.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= init_cnt;
            alg_q <= ALG_KEEP;
        end else begin
            cnt_q <= cnt_d;
            alg_q <= alg_d;
        end
    end

    assign cnt = cnt_q;
    assign alg = alg_q;

endmodule

// File: rtl/pc_open_timer.sv
// Module pc_open_timer
// Open-row lifetime timer. Under keep-open, opening a row or touching the
// open row while its timer runs loads the full timeout; expiry raises a
// one-cycle close request. Under aggressive-close each access requests a
// close in the next cycle and cancels the timer. Timeout 0 is treated as 1.
// Assumes at most one access per cycle.
module pc_open_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             same_row,
    input  logic             close_mode,
    input  logic [TMR_W-1:0] timeout,
    output logic             close_req
);

    localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W-1:0] load_val;
    logic             running;
    logic             keep_load;
    logic             close_q;

    // Decide whether this access (re)starts the lifetime.
    always_comb begin
        running   = (tmr_q != '0);
        load_val  = (timeout == '0) ? TMR_ONE : timeout;
        keep_load = acc_valid && !close_mode && (!same_row || running);
    end

    // Timer countdown and registered close request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            close_q <= 1'b0;
        end else if (acc_valid && close_mode) begin
            tmr_q   <= '0;
            close_q <= 1'b1;
        end else if (keep_load) begin
            tmr_q   <= load_val;
            close_q <= 1'b0;
        end else if (tmr_q == TMR_ONE) begin
            tmr_q   <= '0;
            close_q <= 1'b1;
        end else begin
            if (running) begin
                tmr_q <= tmr_q - 1'b1;
            end
            close_q <= 1'b0;
        end
    end

    assign close_req = close_q;

endmodule

// File: rtl/pc_page_policy.sv
// Module pc_page_policy
// Top of the adaptive page-close policy block. Outcome reports pass a rate
// gate into the mistake tracker, whose selection drives the open-row timer
// and the policy output. Assumes configuration inputs change only while
// idle or in reset; the policy output drops at once when disabled.
module pc_page_policy
    import pc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int TMR_W = 8,
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [CNT_W-1:0] cfg_hi_thr,
    input  logic [CNT_W-1:0] cfg_lo_thr,
    input  logic [CNT_W-1:0] cfg_init_cnt,
    input  logic [TMR_W-1:0] cfg_timeout,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic             ev_valid,
    input  logic             ev_hit,
    input  logic             ev_was_open,
    input  logic             acc_valid,
    input  logic             acc_same_row,
    output logic             policy_close,
    output logic             close_req
);

    ev_e              ev_kind;
    logic             upd_take;
    logic [CNT_W-1:0] mist_cnt;
    alg_e             alg_sel;

    // Classify the incoming outcome report.
    always_comb begin
        ev_kind = classify(ev_hit, ev_was_open);
    end

    pc_rate_gate #(
        .IVL_W (IVL_W)
    ) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_enable),
        .req   (ev_valid),
        .ivl   (cfg_interval),
        .take  (upd_take)
    );

    pc_mistake_track #(
        .CNT_W (CNT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_enable),
        .take     (upd_take),
        .ev       (ev_kind),
        .hi_thr   (cfg_hi_thr),
        .lo_thr   (cfg_lo_thr),
        .init_cnt (cfg_init_cnt),
        .cnt      (mist_cnt),
        .alg      (alg_sel)
    );

    // Policy output: aggressive-close only while the feature is enabled.
    always_comb begin
        policy_close = cfg_enable && (alg_sel == ALG_CLOSE);
    end

    pc_open_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .same_row   (acc_same_row),
        .close_mode (policy_close),
        .timeout    (cfg_timeout),
        .close_req  (close_req)
    );

endmodule

// File: rtl/pc_page_policy_chk.sv
// Module pc_page_policy_chk
// Property checker for pc_page_policy, bound to every instance of the top.
// Watches the port behaviour together with the internal count and the
// rate-gate acceptance strobe.
module pc_page_policy_chk #(
    parameter int CNT_W = 4,
    parameter int IVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [CNT_W-1:0] cfg_init_cnt,
    input logic [IVL_W-1:0] cfg_interval,
    input logic             ev_hit,
    input logic             ev_was_open,
    input logic             acc_valid,
    input logic             policy_close,
    input logic             close_req,
    input logic             upd_take,
    input logic [CNT_W-1:0] mist_cnt
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Raise at the top stays at the top.
    assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && upd_take && ev_was_open && !ev_hit && (mist_cnt == CMAX)
        |=> mist_cnt == CMAX);

    // Lowering at the bottom stays at the bottom.
    assert_sat_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && upd_take && !ev_was_open && ev_hit && (mist_cnt == '0)
        |=> mist_cnt == '0);

    // Correct predictions leave the count alone.
    assert_neutral_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && upd_take && (ev_hit == ev_was_open)
        |=> $stable(mist_cnt));

    // Entry to aggressive-close only follows an accepted raising report.
    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(policy_close) && $past(cfg_enable)
        |-> $past(upd_take && ev_was_open && !ev_hit));

    // Return to keep-open under enable only follows an accepted lowering.
    assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(policy_close) && cfg_enable
        |-> $past(upd_take && !ev_was_open && ev_hit));

    // No back-to-back acceptance when the interval exceeds one.
    assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_take && (cfg_interval > IVL_W'(1))
        |=> !upd_take);

    // Disabled cycles restore the starting count.
    assert_disable_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> mist_cnt == $past(cfg_init_cnt));

    // Aggressive-close answers each access with a close request.
    assert_close_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        policy_close && acc_valid |=> close_req);

endmodule

bind pc_page_policy pc_page_policy_chk #(
    .CNT_W (CNT_W),
    .IVL_W (IVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_init_cnt (cfg_init_cnt),
    .cfg_interval (cfg_interval),
    .ev_hit       (ev_hit),
    .ev_was_open  (ev_was_open),
    .acc_valid    (acc_valid),
    .policy_close (policy_close),
    .close_req    (close_req),
    .upd_take     (upd_take),
    .mist_cnt     (mist_cnt)
);

// File: tb/tb_pc_page_policy.sv
`timescale 1ns/1ps
module tb_pc_page_policy;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b1;
    logic [3:0] cfg_hi_thr = 4'd9;
    logic [3:0] cfg_lo_thr = 4'd2;
    logic [3:0] cfg_init_cnt = 4'd4;
    logic [7:0] cfg_timeout = 8'd4;
    logic [7:0] cfg_interval = 8'd1;
    logic       ev_valid = 1'b0;
    logic       ev_hit = 1'b0;
    logic       ev_was_open = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_same_row = 1'b0;
    logic       policy_close;
    logic       close_req;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // Reference model state, from the requirements.
    int m_cnt;
    int m_alg;
    int cyc;
    int last_acc;

    always #4 clk = ~clk;

    pc_page_policy dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_enable   (cfg_enable),
        .cfg_hi_thr   (cfg_hi_thr),
        .cfg_lo_thr   (cfg_lo_thr),
        .cfg_init_cnt (cfg_init_cnt),
        .cfg_timeout  (cfg_timeout),
        .cfg_interval (cfg_interval),
        .ev_valid     (ev_valid),
        .ev_hit       (ev_hit),
        .ev_was_open  (ev_was_open),
        .acc_valid    (acc_valid),
        .acc_same_row (acc_same_row),
        .policy_close (policy_close),
        .close_req    (close_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset(input int init, input int hi, input int lo,
                            input int tmo, input int ivl, input bit en);
        cfg_init_cnt = 4'(init);
        cfg_hi_thr   = 4'(hi);
        cfg_lo_thr   = 4'(lo);
        cfg_timeout  = 8'(tmo);
        cfg_interval = 8'(ivl);
        cfg_enable   = en;
        ev_valid = 0; ev_hit = 0; ev_was_open = 0; acc_valid = 0; acc_same_row = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(policy_close === 1'b0, "R1 policy in reset", int'(policy_close), 0);
        check(close_req === 1'b0, "R1 close in reset", int'(close_req), 0);
        rst_n = 1'b1;
        m_cnt = init;
        m_alg = 0;
        last_acc = -100000;
    endtask

    // One cycle of stimulus, then the model advances and the policy is checked.
    task automatic step(input bit v, input bit h, input bit o, input bit a, input bit s);
        int ie;
        ev_valid = v; ev_hit = h; ev_was_open = o; acc_valid = a; acc_same_row = s;
        @(negedge clk);
        cyc++;
        ie = (cfg_interval == 0) ? 1 : int'(cfg_interval);
        if (!cfg_enable) begin
            m_cnt = int'(cfg_init_cnt);
            m_alg = 0;
        end else if (v && (cyc - last_acc >= ie)) begin
            last_acc = cyc;
            if (o && !h) begin
                if (m_cnt < 15) m_cnt++;
                if (m_cnt > int'(cfg_hi_thr)) m_alg = 1;
            end else if (!o && h) begin
                if (m_cnt > 0) m_cnt--;
                if (m_cnt < int'(cfg_lo_thr)) m_alg = 0;
            end
        end
        check(policy_close === ((cfg_enable && m_alg == 1) ? 1'b1 : 1'b0),
              "R4 R5 R6 model policy", int'(policy_close), (cfg_enable ? m_alg : 0));
        ev_valid = 0; acc_valid = 0; acc_same_row = 0;
    endtask

    task automatic inc();  step(1, 0, 1, 0, 0); endtask
    task automatic dec();  step(1, 1, 0, 0, 0); endtask
    task automatic idle(); step(0, 0, 0, 0, 0); endtask

    // Timer scenario: open a row, optional same-row access at offset j.
    task automatic timer_case(input int t, input int j);
        int te;
        int expk;
        string tag;
        te = (t == 0) ? 1 : t;
        do_reset(4, 9, 2, t, 1, 1);
        step(0, 0, 0, 1, 0);
        check(close_req === 1'b0, "R7 no close on open", int'(close_req), 0);
        if (j == 0) begin
            expk = te; tag = "R7 timeout close";
        end else if (j <= te) begin
            expk = j + te; tag = "R8 reload close";
        end else begin
            expk = te; tag = "R9 late same-row ignored";
        end
        for (int k = 1; k <= te + j + 3; k++) begin
            step(0, 0, 0, (k == j), 1'b1);
            check(close_req === ((k == expk) ? 1'b1 : 1'b0), tag,
                  int'(close_req), (k == expk) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int need;
        cyc = 0;

        // Threshold sweep: neutral reports, then raises, then lowerings.
        for (int lo = 1; lo <= 6; lo++) begin
            for (int hi = lo; hi <= lo + 7 && hi <= 14; hi++) begin
                int init;
                init = (lo + hi) / 2;
                do_reset(init, hi, lo, 4, 1, 1);
                step(1, 1, 1, 0, 0);
                step(1, 0, 0, 0, 0);
                check(policy_close === 1'b0, "R2 neutral reports", int'(policy_close), 0);
                need = hi - init + 1;
                for (int k = 1; k <= need; k++) begin
                    inc();
                    check(policy_close === ((k == need) ? 1'b1 : 1'b0),
                          "R1 R4 raises to switch", int'(policy_close), (k == need) ? 1 : 0);
                end
                need = hi - lo + 2;
                for (int k = 1; k <= need; k++) begin
                    dec();
                    check(policy_close === ((k < need) ? 1'b1 : 1'b0),
                          "R4 lowerings to switch back", int'(policy_close), (k < need) ? 1 : 0);
                end
            end
        end

        // Upper saturation: from 10, ten raises then two lowerings needed.
        do_reset(10, 11, 14, 4, 1, 1);
        for (int k = 0; k < 10; k++) inc();
        dec();
        check(policy_close === 1'b1, "R3 top saturation first lowering", int'(policy_close), 1);
        dec();
        check(policy_close === 1'b0, "R3 top saturation second lowering", int'(policy_close), 0);

        // Lower saturation: ten lowerings from 5, then seven raises exceed 6.
        do_reset(5, 6, 4, 4, 1, 1);
        for (int k = 0; k < 10; k++) dec();
        for (int k = 1; k <= 7; k++) begin
            inc();
            check(policy_close === ((k == 7) ? 1'b1 : 1'b0), "R3 bottom saturation",
                  int'(policy_close), (k == 7) ? 1 : 0);
        end

        // Rate gate: raises every cycle; only one per interval counts.
        for (int iv = 0; iv <= 5; iv++) begin
            int ie;
            ie = (iv == 0) ? 1 : iv;
            do_reset(4, 9, 2, 4, iv, 1);
            for (int k = 0; k < 6 * ie + 2; k++) begin
                inc();
                check(policy_close === ((k >= 5 * ie) ? 1'b1 : 1'b0), "R5 interval gating",
                      int'(policy_close), (k >= 5 * ie) ? 1 : 0);
            end
        end

        // Disable: reports ignored, re-enable restarts from the initial count.
        do_reset(7, 8, 3, 4, 1, 0);
        for (int k = 0; k < 5; k++) begin
            inc();
            check(policy_close === 1'b0, "R6 disabled ignores reports", int'(policy_close), 0);
        end
        cfg_enable = 1'b1;
        inc();
        check(policy_close === 1'b0, "R6 first raise after enable", int'(policy_close), 0);
        inc();
        check(policy_close === 1'b1, "R6 second raise after enable", int'(policy_close), 1);
        cfg_enable = 1'b0;
        idle();
        check(policy_close === 1'b0, "R6 disable forces keep-open", int'(policy_close), 0);
        cfg_enable = 1'b1;
        idle();
        check(policy_close === 1'b0, "R6 re-enable restarts learning", int'(policy_close), 0);

        // Timer: plain expiry for several timeouts.
        for (int t = 0; t <= 6; t++) timer_case(t, 0);
        // Timer: same-row access at every offset, including the expiry cycle.
        for (int j = 1; j <= 5; j++) timer_case(4, j);
        // Timer: same-row access just after expiry.
        timer_case(3, 4);

        // Same-row access with no row open.
        do_reset(4, 9, 2, 3, 1, 1);
        step(0, 0, 0, 1, 1);
        for (int k = 0; k < 6; k++) begin
            idle();
            check(close_req === 1'b0, "R9 same-row with nothing open", int'(close_req), 0);
        end

        // Aggressive-close: immediate close and cancelled timer.
        do_reset(8, 8, 3, 3, 1, 1);
        step(0, 0, 0, 1, 0);
        inc();
        check(policy_close === 1'b1, "R10 entered close mode", int'(policy_close), 1);
        step(0, 0, 0, 1, 1);
        check(close_req === 1'b1, "R10 close after access", int'(close_req), 1);
        step(0, 0, 0, 1, 0);
        check(close_req === 1'b1, "R10 back-to-back close", int'(close_req), 1);
        for (int k = 0; k < 6; k++) begin
            idle();
            check(close_req === 1'b0, "R10 no timeout close", int'(close_req), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule